// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block turns a host configuration request, given as bus number, device number, function number, register offset, access length and write data, into a single 32-bit configuration-space transaction on a downstream memory port. Alongside each accepted request it updates a window-select value. The surrounding fabric uses that value to choose the configuration window for the access. The block also drives the word-aligned address of the access.

Bus 0 requests become type 0 cycles. The one-hot device-select bit is placed at position device + 16. Its top part falls inside the window field (bits 31:26), and that part goes into the window-select value. The rest of the bit is carried in the address. Requests on any other bus become type 1 cycles, with the bus, device, function and register packed into the address.

Reads return the addressed lane shifted down to bit 0. Byte and halfword writes are done as a read of the word, a merge of the new lane and a write of the word back. Illegal requests and downstream faults end with an error response. Only one request is in flight at a time.

Top module: `cfgx_translator`

## Requirements
- R1: A request with bus 0 forms a one-hot value with bit (device + 16) set. Window-select becomes 0x2 OR the bits of that value in positions 31:26. The address is CFG_BASE (default 0x0C000000) OR the one-hot bits below 26 OR function<<8 OR (offset AND 0xFC).
- R2: A request on a non-zero bus loads window-select with 0x3. Its address is CFG_BASE OR bus<<16 OR device<<11 OR function<<8 OR (offset AND 0xFC) OR 0x1.
- R3: On bus 0 a device number of 16 or more ends in an error response.
- R4: While cardbus_en_i is high, any device number above 1 ends in an error response, on any bus.
- R5: Only lengths 1, 2 and 4 (req_len_i holds the byte count) are legal. Any other length ends in an error response.
- R6: A rejected request makes no downstream access, returns read data 0 and leaves window-select unchanged.
- R7: A read returns the word shifted right by 8 × (offset mod 4), masked to the low 8, 16 or 32 bits by the length.
- R8: A write of length 1 or 2 reads the word, clears the target lane, ORs in the masked data shifted left by 8 × (offset mod 4) and writes the word back, making two downstream accesses.
- R9: A write of length 4 stores req_wdata_i with exactly one downstream access and no read.
- R10: A downstream fault ends the request with an error response, read data 0, and no further downstream access.
- R11: A request is taken only while req_ready_o is high. busy_o stays high and req_ready_o low from acceptance until the one-cycle rsp_valid_o pulse has ended.
- R12: After reset, req_ready_o is high, busy_o, rsp_valid_o and mem_req_o are low, and window-select equals 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cardbus_en_i | input | 1 | Restricts legal devices to 0 and 1 |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Bus number |
| req_dev_i | input | 5 | Device number |
| req_func_i | input | 3 | Function number |
| req_off_i | input | 8 | Register byte offset |
| req_len_i | input | 3 | Access length in bytes |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Completion carries an error |
| rsp_rdata_o | output | 32 | Aligned read data |
| busy_o | output | 1 | A request is in progress |
| window_o | output | 32 | Window-select value |
| mem_req_o | output | 1 | Downstream access pending |
| mem_we_o | output | 1 | Downstream access is a write |
| mem_addr_o | output | 32 | Downstream word address |
| mem_wdata_o | output | 32 | Downstream write word |
| mem_ack_i | input | 1 | Downstream completion, one cycle |
| mem_fault_i | input | 1 | Downstream completion faulted |
| mem_rdata_i | input | 32 | Downstream read word |

## Verification
The assertions assume that the downstream port raises mem_ack_i only while mem_req_o is high, for a single cycle per access, and that mem_fault_i and mem_rdata_i count only in that cycle. The memory model in the bench answers only a pending access. After a chosen latency it acknowledges once, then drops the acknowledge before counting again. This also covers the read-then-write turn inside a merge. Requests are driven only while req_ready_o is high, so the single-outstanding rule is never pushed from outside.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_RSP  = 2'd3
  } cfgx_state_e;

  function automatic logic len_legal(input logic [2:0] len);
    return (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
  endfunction

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FUNC_W    = 3,
  parameter int OFF_W     = 8,
  parameter int NUM_SLOTS = 16,
  parameter int IDSEL_LSB = 16,
  parameter int WIN_LSB   = 26,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [ADDR_W-1:0] CODE_T0  = 32'h0000_0002,
  parameter logic [ADDR_W-1:0] CODE_T1  = 32'h0000_0003
) (
  input  logic              cardbus_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [2:0]        len_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] win_o
);

  localparam logic [ADDR_W-1:0] WIN_MASK = {ADDR_W{1'b1}} << WIN_LSB;
  localparam int FUNC_LSB = OFF_W;
  localparam int DEV_LSB  = FUNC_LSB + FUNC_W;
  localparam int BUS_LSB  = DEV_LSB + DEV_W;

  logic [ADDR_W-1:0] idsel;
  logic [ADDR_W-1:0] reg_part, func_part, t0_addr, t1_addr;
  logic              is_t0, slot_ok, cb_ok;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_idsel
    if (b >= IDSEL_LSB && b < IDSEL_LSB + NUM_SLOTS) begin : g_slot
      assign idsel[b] = (dev_i == DEV_W'(b - IDSEL_LSB));
    end else begin : g_zero
      assign idsel[b] = 1'b0;
    end
  end

  assign is_t0     = (bus_i == '0);
  assign slot_ok   = !is_t0 || (32'(dev_i) < NUM_SLOTS);
  assign cb_ok     = !cardbus_i || (32'(dev_i) <= 1);
  assign ok_o      = len_legal(len_i) && slot_ok && cb_ok;

  assign reg_part  = ADDR_W'({off_i[OFF_W-1:2], 2'b00});
  assign func_part = ADDR_W'(func_i) << FUNC_LSB;

  // type 0: select bits outside the window ride in the address
  assign t0_addr = CFG_BASE | (idsel & ~WIN_MASK) | func_part | reg_part;
  assign t1_addr = CFG_BASE | (ADDR_W'(bus_i) << BUS_LSB) | (ADDR_W'(dev_i) << DEV_LSB)
                 | func_part | reg_part | ADDR_W'(2'b01);

  assign addr_o = is_t0 ? t0_addr : t1_addr;
  assign win_o  = is_t0 ? (CODE_T0 | (idsel & WIN_MASK)) : CODE_T1;

endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        len_i,
  input  logic [1:0]        off2_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_o,
  output logic [DATA_W-1:0] merged_o
);

  logic [4:0]        shift;
  logic [DATA_W-1:0] lmask;

  assign shift = {off2_i, 3'b000};

  always_comb begin
    case (len_i)
      3'd1:    lmask = DATA_W'(8'hFF);
      3'd2:    lmask = DATA_W'(16'hFFFF);
      default: lmask = '1;
    endcase
  end

  assign rd_o     = (word_i >> shift) & lmask;
  assign merged_o = (len_i == 3'd4) ? wdata_i
                  : ((word_i & ~(lmask << shift)) | ((wdata_i & lmask) << shift));

endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CODE_T0 = 32'h0000_0002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [2:0]        req_len_i,
  input  logic [1:0]        req_off2_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              dec_ok_i,
  input  logic [ADDR_W-1:0] dec_addr_i,
  input  logic [ADDR_W-1:0] dec_win_i,
  input  logic [DATA_W-1:0] rd_aligned_i,
  input  logic [DATA_W-1:0] wr_merged_i,
  input  logic              mem_ack_i,
  input  logic              mem_fault_i,
  output logic              req_ready_o,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] window_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [2:0]        lat_len_o,
  output logic [1:0]        lat_off2_o,
  output logic [DATA_W-1:0] lat_wdata_o
);

  cfgx_state_e state_q;
  logic        wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      window_o    <= CODE_T0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      lat_len_o   <= '0;
      lat_off2_o  <= '0;
      lat_wdata_o <= '0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q        <= req_write_i;
          lat_len_o   <= req_len_i;
          lat_off2_o  <= req_off2_i;
          lat_wdata_o <= req_wdata_i;
          rsp_rdata_o <= '0;
          if (!dec_ok_i) begin
            rsp_err_o <= 1'b1;
            state_q   <= ST_RSP;
          end else begin
            rsp_err_o  <= 1'b0;
            window_o   <= dec_win_i;
            mem_addr_o <= dec_addr_i;
            if (req_write_i && req_len_i == 3'd4) begin
              mem_wdata_o <= req_wdata_i;
              state_q     <= ST_WR;
            end else begin
              state_q <= ST_RD;
            end
          end
        end
        ST_RD: if (mem_ack_i) begin
          if (mem_fault_i) begin
            rsp_err_o <= 1'b1;
            state_q   <= ST_RSP;
          end else if (wr_q) begin
            mem_wdata_o <= wr_merged_i;
            state_q     <= ST_WR;
          end else begin
            rsp_rdata_o <= rd_aligned_i;
            state_q     <= ST_RSP;
          end
        end
        ST_WR: if (mem_ack_i) begin
          rsp_err_o <= mem_fault_i;
          state_q   <= ST_RSP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RSP);
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
  import cfgx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FUNC_W    = 3,
  parameter int OFF_W     = 8,
  parameter int NUM_SLOTS = 16,
  parameter int IDSEL_LSB = 16,
  parameter int WIN_LSB   = 26,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [ADDR_W-1:0] CODE_T0  = 32'h0000_0002,
  parameter logic [ADDR_W-1:0] CODE_T1  = 32'h0000_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cardbus_en_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BUS_W-1:0]  req_bus_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [FUNC_W-1:0] req_func_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [2:0]        req_len_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] window_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_fault_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  logic              dec_ok;
  logic [ADDR_W-1:0] dec_addr, dec_win;
  logic [DATA_W-1:0] rd_aligned, wr_merged, lat_wdata;
  logic [2:0]        lat_len;
  logic [1:0]        lat_off2;

  cfgx_decode #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W),
    .NUM_SLOTS(NUM_SLOTS), .IDSEL_LSB(IDSEL_LSB), .WIN_LSB(WIN_LSB),
    .CFG_BASE(CFG_BASE), .CODE_T0(CODE_T0), .CODE_T1(CODE_T1)
  ) u_decode (
    .cardbus_i(cardbus_en_i),
    .bus_i    (req_bus_i),
    .dev_i    (req_dev_i),
    .func_i   (req_func_i),
    .off_i    (req_off_i),
    .len_i    (req_len_i),
    .ok_o     (dec_ok),
    .addr_o   (dec_addr),
    .win_o    (dec_win)
  );

  cfgx_lane #(.DATA_W(DATA_W)) u_lane (
    .len_i   (lat_len),
    .off2_i  (lat_off2),
    .word_i  (mem_rdata_i),
    .wdata_i (lat_wdata),
    .rd_o    (rd_aligned),
    .merged_o(wr_merged)
  );

  cfgx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_T0(CODE_T0)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_len_i   (req_len_i),
    .req_off2_i  (req_off_i[1:0]),
    .req_wdata_i (req_wdata_i),
    .dec_ok_i    (dec_ok),
    .dec_addr_i  (dec_addr),
    .dec_win_i   (dec_win),
    .rd_aligned_i(rd_aligned),
    .wr_merged_i (wr_merged),
    .mem_ack_i   (mem_ack_i),
    .mem_fault_i (mem_fault_i),
    .req_ready_o (req_ready_o),
    .busy_o      (busy_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o),
    .window_o    (window_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .lat_len_o   (lat_len),
    .lat_off2_o  (lat_off2),
    .lat_wdata_o (lat_wdata)
  );

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cardbus_en_i,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        req_write_i,
  input logic [7:0]  req_bus_i,
  input logic [4:0]  req_dev_i,
  input logic [2:0]  req_func_i,
  input logic [7:0]  req_off_i,
  input logic [2:0]  req_len_i,
  input logic [31:0] req_wdata_i,
  input logic        rsp_valid_o,
  input logic        rsp_err_o,
  input logic [31:0] rsp_rdata_o,
  input logic        busy_o,
  input logic [31:0] window_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic        mem_fault_i,
  input logic [31:0] mem_rdata_i
);

  logic take;
  assign take = req_valid_i && req_ready_o;

  a_r5_bad_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !(req_len_i == 3'd1 || req_len_i == 3'd2 || req_len_i == 3'd4)
    |=> rsp_valid_o && rsp_err_o);

  a_r3_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && req_bus_i == 8'd0 && req_dev_i >= 5'd16 |=> rsp_valid_o && rsp_err_o);

  a_r4_cardbus_dev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cardbus_en_i && req_dev_i > 5'd1 |=> rsp_valid_o && rsp_err_o && !mem_req_o);

  a_r10_fault_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && mem_fault_i |=> !mem_req_o && rsp_valid_o && rsp_err_o);

  a_r11_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  a_r11_no_rsp_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !rsp_valid_o && busy_o);

  a_r1_window_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) |-> $stable(window_o) && $stable(mem_addr_o));

  a_r8_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i && !mem_fault_i && req_write_i == req_write_i
    && busy_o |=> (mem_req_o && mem_we_o) || rsp_valid_o);

endmodule

bind cfgx_translator cfgx_checker u_cfgx_checker (.*);

// File: tb/tb_cfgx_translator.sv
module tb_cfgx_translator;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0C00_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cardbus_en_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [7:0]  req_bus_i = '0;
  logic [4:0]  req_dev_i = '0;
  logic [2:0]  req_func_i = '0;
  logic [7:0]  req_off_i = '0;
  logic [2:0]  req_len_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o, rsp_err_o, busy_o;
  logic [31:0] rsp_rdata_o, window_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic        mem_fault_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cfgx_translator dut (.*);

  typedef struct {
    string       tag;
    logic        err;
    logic [31:0] rdata;
    int          acc;
    logic [31:0] win;
    logic [31:0] addr;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int acc_cnt = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] cur_win = 32'h2;
  bit fault_en = 0;
  int lat_sel = 0;
  int lat_cnt = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] ref_mem [int unsigned];

  function automatic logic [31:0] init_word(logic [31:0] a);
    return a ^ 32'h5A3C_96E1;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // downstream memory model
  always @(negedge clk_i) begin
    if (mem_ack_i) begin
      mem_ack_i   = 1'b0;
      mem_fault_i = 1'b0;
    end else if (mem_req_o) begin
      if (lat_cnt >= lat_sel) begin
        lat_cnt     = 0;
        mem_ack_i   = 1'b1;
        mem_fault_i = fault_en;
        mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : init_word(mem_addr_o);
        acc_cnt++;
        last_addr = mem_addr_o;
        if (mem_we_o && !fault_en) mem[mem_addr_o] = mem_wdata_o;
      end else lat_cnt++;
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected response actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "err", 32'(rsp_err_o), 32'(e.err));
        check(e.tag, "rdata", rsp_rdata_o, e.rdata);
        check(e.tag, "accesses", acc_cnt, e.acc);
        check(e.tag, "window", window_o, e.win);
        if (e.acc > 0) check(e.tag, "addr", last_addr, e.addr);
      end
    end
  end

  task automatic do_req(string tag, bit wr, int bus, int dev, int func, int off, int len,
                        logic [31:0] wdata, bit cb, bit flt, int lat);
    exp_t e;
    bit ok;
    logic [31:0] onehot, addr, win, word, lm, sh;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    ok = (len == 1 || len == 2 || len == 4) && (bus != 0 || dev < 16) && (!cb || dev <= 1);
    onehot = 32'h1 << (dev + 16);
    if (bus == 0) begin
      addr = BASE | (onehot & 32'h03FF_FFFF) | (32'(func) << 8) | (32'(off) & 32'hFC);
      win  = 32'h2 | (onehot & 32'hFC00_0000);
    end else begin
      addr = BASE | (32'(bus) << 16) | (32'(dev) << 11) | (32'(func) << 8)
           | (32'(off) & 32'hFC) | 32'h1;
      win  = 32'h3;
    end
    lm = (len == 1) ? 32'hFF : (len == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    sh = 32'(8 * (off % 4));
    e.tag = tag; e.err = 0; e.rdata = 0; e.acc = 0; e.addr = addr;
    if (!ok) begin
      e.err = 1; e.win = cur_win;
    end else begin
      cur_win = win; e.win = win;
      word = ref_mem.exists(addr) ? ref_mem[addr] : init_word(addr);
      if (flt) begin
        e.err = 1; e.acc = 1;
      end else if (!wr) begin
        e.rdata = (word >> sh) & lm; e.acc = 1;
      end else if (len == 4) begin
        ref_mem[addr] = wdata; e.acc = 1;
      end else begin
        ref_mem[addr] = (word & ~(lm << sh)) | ((wdata & lm) << sh); e.acc = 2;
      end
    end
    exp_q.push_back(e);
    acc_cnt = 0; fault_en = flt; lat_sel = lat; lat_cnt = 0;
    cardbus_en_i = cb; req_write_i = wr; req_bus_i = 8'(bus); req_dev_i = 5'(dev);
    req_func_i = 3'(func); req_off_i = 8'(off); req_len_i = 3'(len); req_wdata_i = wdata;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    // R11: busy after acceptance
    check("R11", "ready after accept", 32'(req_ready_o), 32'h0);
    check("R11", "busy after accept", 32'(busy_o), 32'h1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    check("R12", "ready", 32'(req_ready_o), 32'h1);
    check("R12", "busy", 32'(busy_o), 32'h0);
    check("R12", "rsp_valid", 32'(rsp_valid_o), 32'h0);
    check("R12", "mem_req", 32'(mem_req_o), 32'h0);
    check("R12", "window", window_o, 32'h2);

    do_req("R1",  0, 0, 3, 1, 8'h10, 4, 0, 0, 0, 0);
    do_req("R1",  0, 0, 12, 2, 8'h0D, 1, 0, 0, 0, 2);
    do_req("R7",  0, 0, 9, 0, 8'h0F, 1, 0, 0, 0, 1);
    do_req("R2",  0, 2, 7, 5, 8'h3E, 2, 0, 0, 0, 1);
    do_req("R5",  0, 0, 1, 0, 8'h00, 3, 0, 0, 0, 0);
    do_req("R6",  1, 0, 1, 0, 8'h00, 0, 32'h1234, 0, 0, 0);
    do_req("R3",  0, 0, 16, 0, 8'h00, 4, 0, 0, 0, 0);
    do_req("R3",  0, 0, 15, 7, 8'hFC, 4, 0, 0, 0, 0);
    do_req("R4",  0, 1, 2, 0, 8'h08, 4, 0, 1, 0, 0);
    do_req("R4",  0, 0, 1, 0, 8'h08, 4, 0, 1, 0, 0);
    do_req("R9",  1, 0, 4, 0, 8'h20, 4, 32'hDEAD_BEEF, 0, 0, 1);
    do_req("R8",  1, 0, 4, 0, 8'h21, 1, 32'hFFFF_FF5A, 0, 0, 0);
    do_req("R8",  0, 0, 4, 0, 8'h20, 4, 0, 0, 0, 0);
    do_req("R8",  1, 3, 6, 1, 8'h42, 2, 32'h0000_C0DE, 0, 0, 2);
    do_req("R8",  0, 3, 6, 1, 8'h40, 4, 0, 0, 0, 0);
    do_req("R10", 0, 0, 5, 0, 8'h30, 4, 0, 0, 1, 1);
    do_req("R10", 1, 0, 5, 0, 8'h31, 1, 32'h77, 0, 1, 0);
    do_req("R7",  0, 0, 5, 0, 8'h32, 2, 0, 0, 0, 0);

    while (exp_q.size() != 0 || !req_ready_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    check("R11", "ready at end", 32'(req_ready_o), 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule